// File: doc/BRIEF.md
# Memory Word Increment Unit

This block runs a read-modify-write count on a word held in a synchronous single-port memory. A requester raises an increment strobe and supplies a word address and a two-bit field selector. The unit reads the addressed 24-bit word. In the next cycle it writes back the word with the chosen field increased by one. In that same write-back cycle it pulses a done signal, together with a flag that tells whether the incremented field wrapped to zero.

The selector picks the whole 24-bit word or one of its two 12-bit halves. When a half is selected, the carry stays inside that half and the other half goes back to memory unchanged. The zero flag looks only at the selected field. Each operation takes one read cycle and one write cycle, so the fastest rate is one count every two cycles. A strobe that arrives during a write-back cycle is not taken, because the single memory port is busy with the write.

Top module: `mem_incr_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, done, zero, mem_en and mem_we are all low.
- R2: A strobe seen with the unit idle gives a memory read in that same cycle (mem_en=1, mem_we=0, mem_addr=req_addr). The next cycle is a write (mem_en=1, mem_we=1) to the same address.
- R3: Selector 2'b00 and the reserved code 2'b11 both increment the whole 24-bit word modulo 2^24.
- R4: Selector 2'b01 increments bits [11:0] modulo 2^12 and writes bits [23:12] back unchanged, with no carry into them.
- R5: Selector 2'b10 increments bits [23:12] modulo 2^12 and writes bits [11:0] back unchanged.
- R6: In the write-back cycle, zero is 1 exactly when the selected field of the written value is zero. Zero is 0 in every cycle where done is 0.
- R7: Done is a single-cycle pulse in the write-back cycle. There is exactly one pulse for each accepted strobe.
- R8: A strobe present during a write-back cycle is ignored. When the strobe is held high, operations are accepted on alternate cycles, giving one count per two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Increment strobe |
| req_addr | input | ADDR_W | Address of the word to count |
| req_field | input | 2 | Field selector: 00 full, 01 lower half, 10 upper half, 11 full |
| done | output | 1 | Write-back pulse |
| zero | output | 1 | Selected field became zero (valid with done) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 24 | Incremented word to store |
| mem_rdata | input | 24 | Word read, one cycle after the read enable |

## Verification
The read request appears combinationally in the strobe cycle. The bench therefore samples mem_en, mem_we and mem_addr shortly after it drives the strobe, before the clock edge. Done, zero and the write-back signals belong to the cycle that follows the accepting edge, so they are sampled on the next falling edge. The memory content is compared one edge later, after the write has landed. Every field code is swept over wrap-boundary and pseudo-random words, with expected words computed arithmetically. A run with the strobe held high counts done pulses cycle by cycle to show that only alternate cycles are accepted.

// File: rtl/mem_incr_pkg.sv
package mem_incr_pkg;
  localparam int WORD_W = 24;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {
    FLD_FULL = 2'b00,
    FLD_LO   = 2'b01,
    FLD_HI   = 2'b10,
    FLD_RSVD = 2'b11
  } fld_e;

  // Next value of the word with only the chosen field counted up.
  function automatic logic [WORD_W-1:0] bump_word(input logic [WORD_W-1:0] w,
                                                  input fld_e sel);
    logic [WORD_W-1:0] r;
    logic [HALF_W-1:0] h;
    r = w;
    case (sel)
      FLD_LO: begin
        h = w[HALF_W-1:0] + 1'b1;
        r = {w[WORD_W-1:HALF_W], h};
      end
      FLD_HI: begin
        h = w[WORD_W-1:HALF_W] + 1'b1;
        r = {h, w[HALF_W-1:0]};
      end
      default: r = w + 1'b1;
    endcase
    return r;
  endfunction

  // Zero test restricted to the chosen field.
  function automatic logic field_zero(input logic [WORD_W-1:0] w, input fld_e sel);
    logic z;
    case (sel)
      FLD_LO:  z = (w[HALF_W-1:0] == '0);
      FLD_HI:  z = (w[WORD_W-1:HALF_W] == '0);
      default: z = (w == '0);
    endcase
    return z;
  endfunction
endpackage

// File: rtl/mem_incr_ctrl.sv
module mem_incr_ctrl
  import mem_incr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_field,
  output logic              rd_fire,
  output logic              wb_active,
  output logic [ADDR_W-1:0] addr_q,
  output fld_e              field_q
);
  typedef enum logic {ST_IDLE = 1'b0, ST_WB = 1'b1} st_e;
  st_e state_q;

  assign rd_fire   = req_valid && (state_q == ST_IDLE);
  assign wb_active = (state_q == ST_WB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      field_q <= FLD_FULL;
    end else begin
      case (state_q)
        ST_IDLE: if (rd_fire) begin
          state_q <= ST_WB;
          addr_q  <= req_addr;
          field_q <= fld_e'(req_field);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  rd_then_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> wb_active);
  // R8
  no_back_to_back_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_active |=> !wb_active);
endmodule

// File: rtl/mem_incr_alu.sv
module mem_incr_alu
  import mem_incr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  fld_e              field,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] wdata,
  output logic              is_zero
);
  assign wdata   = bump_word(rdata, field);
  assign is_zero = field_zero(wdata, field);

  // R4
  lo_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && field == FLD_LO) |-> wdata[WORD_W-1:HALF_W] == rdata[WORD_W-1:HALF_W]);
  // R5
  hi_keeps_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && field == FLD_HI) |-> wdata[HALF_W-1:0] == rdata[HALF_W-1:0]);
endmodule

// File: rtl/mem_incr_unit.sv
module mem_incr_unit
  import mem_incr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_field,
  output logic              done,
  output logic              zero,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [23:0]       mem_wdata,
  input  logic [23:0]       mem_rdata
);
  logic              rd_fire;
  logic              wb_active;
  logic [ADDR_W-1:0] addr_q;
  fld_e              field_q;
  logic              alu_zero;

  mem_incr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_field(req_field), .rd_fire(rd_fire), .wb_active(wb_active),
    .addr_q(addr_q), .field_q(field_q)
  );

  mem_incr_alu u_alu (
    .clk(clk), .rst_n(rst_n), .active(wb_active), .field(field_q),
    .rdata(mem_rdata), .wdata(mem_wdata), .is_zero(alu_zero)
  );

  assign mem_en   = rd_fire | wb_active;
  assign mem_we   = wb_active;
  assign mem_addr = wb_active ? addr_q : req_addr;
  assign done     = wb_active;
  assign zero     = wb_active & alu_zero;

  // R6
  zero_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> done);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  wb_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (mem_we && mem_addr == $past(mem_addr)));
endmodule

// File: tb/mem_incr_unit_tb.sv
module mem_incr_unit_tb;
  localparam int CLK_P  = 10;
  localparam int AW     = 4;
  localparam int DEPTH  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_field = '0;
  logic          done, zero, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [23:0]   mem_wdata;
  logic [23:0]   mem_rdata;
  logic [23:0]   ram [DEPTH];
  int            n_chk = 0;
  int            n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  mem_incr_unit #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_field(req_field), .done(done), .zero(zero), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input logic [23:0] w, input logic [1:0] f);
    logic [23:0] r;
    if (f == 2'b01)      r = (w & 24'hFFF000) | ((w + 24'd1) & 24'h000FFF);
    else if (f == 2'b10) r = (w & 24'h000FFF) | ((w + 24'h001000) & 24'hFFF000);
    else                 r = (w + 24'd1) & 24'hFFFFFF;
    return r;
  endfunction

  function automatic logic model_zero(input logic [23:0] w, input logic [1:0] f);
    if (f == 2'b01) return (w % 4096) == 0;
    if (f == 2'b10) return (w / 4096) == 0;
    return w == 0;
  endfunction

  task automatic one_incr(input logic [AW-1:0] a, input logic [1:0] f, input logic [23:0] init);
    logic [23:0] exp;
    string tag;
    exp = model(init, f);
    tag = (f == 2'b01) ? "R4" : (f == 2'b10) ? "R5" : "R3";
    @(negedge clk);
    ram[a] = init;
    req_valid = 1'b1; req_addr = a; req_field = f;
    #1;
    check("R2 read en", {mem_en, mem_we}, 2'b10);
    check("R2 read addr", mem_addr, a);
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 done", done, 1'b1);
    check("R2 write", {mem_en, mem_we}, 2'b11);
    check("R2 write addr", mem_addr, a);
    check(tag, mem_wdata, exp);
    check("R6 zero", zero, model_zero(exp, f));
    @(negedge clk);
    check("R7 pulse end", {done, zero}, 2'b00);
    check(tag, ram[a], exp);
  endtask

  initial begin
    logic [23:0] pats [10];
    logic [23:0] lfsr;
    int pulses;
    pats = '{24'h000000, 24'hFFFFFF, 24'h000FFF, 24'hFFF000, 24'hFFEFFF,
             24'h7FF7FF, 24'hABCFFF, 24'hFFFABC, 24'h123456, 24'hFFFFFE};
    for (int i = 0; i < DEPTH; i++) ram[i] = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 in reset", {done, zero, mem_en, mem_we}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {done, zero, mem_en, mem_we}, 4'b0000);

    for (int f = 0; f < 4; f++) begin
      for (int p = 0; p < 10; p++) one_incr(AW'(p + f), 2'(f), pats[p]);
    end
    lfsr = 24'hACE1F5;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      one_incr(AW'(k), 2'(k), lfsr);
    end

    // R8: strobe held for 6 cycles, accepted on alternate cycles
    @(negedge clk);
    ram[5] = 24'h000FFE;
    req_valid = 1'b1; req_addr = 4'd5; req_field = 2'b01;
    pulses = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (done) pulses++;
      check("R8 alternate", done, (c % 2 == 0) ? 1'b1 : 1'b0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    if (done) pulses++;
    check("R8 pulse count", pulses, 3);
    check("R8 final value", ram[5], 24'h000001);

    // R8: strobe only in write-back cycle ignored
    @(negedge clk);
    ram[6] = 24'h000010;
    req_valid = 1'b1; req_addr = 4'd6; req_field = 2'b00;
    @(negedge clk);
    req_addr = 4'd7; ram[7] = 24'h000020;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 no done after ignored strobe", done, 1'b0);
    @(negedge clk);
    check("R8 ignored word untouched", ram[7], 24'h000020);
    check("R8 first word", ram[6], 24'h000011);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule